// File: doc/BRIEF.md
# Flux Bit-Cell Read Pulse Generator

This block turns a stored track bitstream into a stream of read pulses for a downstream disk sequencer. A phase accumulator advances by a fixed step on every 2 MHz tick. Four units of the accumulator equal 0.5 us. When the accumulator reaches a programmable bit-cell period, one bit cell has elapsed. The block then reads the bit under the head from a byte-wide track memory port, most significant bit first, and shifts that bit into a four-deep flux history. It emits one read pulse taken from that history.

The pulse lags the flux by one cell, because it comes from the second-newest history bit. Whenever the newest four flux bits are all zero, the pulse is taken from a noise byte at the same position instead. This models the random pulses a real read amplifier produces when no flux transitions arrive. The noise comes from an external noise-track port by default. A parameter can select an internal LFSR instead. The track length in bits is an input, and the bit position wraps at that length.

Top module: `flux_pulse_gen`

## Requirements
- R1: After reset, rd_pulse_o is 0, byte_addr_o is 0 and bit_idx_o is 7 (accumulator, history and position all cleared).
- R2: Each cycle with tick_i high adds 4 to the accumulator. A bit cell completes on that tick when the sum is at or above bit_time_i, and at most one cell completes per tick.
- R3: On completion, bit_time_i is subtracted from the sum rather than clearing it, so that for example a period of 14 yields cells spaced 4,3,4,3 ticks.
- R4: The bit position P maps to byte_addr_o = P >> 3 and bit_idx_o = 7 - P[2:0], and the bit read is trk_byte_i[bit_idx_o], so bits leave each byte MSB-first.
- R5: On a completing tick the read bit enters the LSB of a 4-bit history. If that updated history is non-zero, the pulse equals its bit 1.
- R6: If the updated history is 0000, the pulse equals bit bit_idx_o of noise_byte_i, taken at the same position.
- R7: rd_pulse_o is high only in the cycle after a completing tick, and it is 0 after any tick without completion and after any cycle without a tick.
- R8: On completion the position becomes P+1, or 0 when P+1 is at or above bit_count_i.
- R9: The position and history do not change in cycles without a completing tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle 2 MHz time-base strobe |
| bit_time_i | input | ACC_W | Bit-cell period in accumulator units (at least 4) |
| bit_count_i | input | POS_W | Track length in bits |
| trk_byte_i | input | 8 | Track byte at byte_addr_o (combinational read) |
| noise_byte_i | input | 8 | Noise-track byte at byte_addr_o |
| rd_pulse_o | output | 1 | Registered read pulse |
| byte_addr_o | output | POS_W-3 | Byte index of the current bit position |
| bit_idx_o | output | 3 | Bit index within the byte, 7 = MSB |

## Verification
The hardest situation to reach is noise substitution. It needs four consecutive zero cells on the track while the head is at a byte whose noise bits differ from the flux-derived value. The bench fills a block of the track with zero bytes and loads the noise track with a mixed pattern, so the substitution is visible on the pulse. Uneven tick patterns and a period that is not a multiple of the step exercise the remainder carry. A track length that is not a multiple of eight forces the wrap in the middle of a byte.

// File: rtl/flux_pkg.sv
package flux_pkg;

  typedef enum logic {
    NOISE_PORT = 1'b0,
    NOISE_LFSR = 1'b1
  } noise_src_e;

  // Select one bit of a byte by index (7 = MSB).
  function automatic logic pick_bit(input logic [7:0] b, input logic [2:0] idx);
    return b[idx];
  endfunction

  // Map a position's low bits to an MSB-first bit index.
  function automatic logic [2:0] msb_first_idx(input logic [2:0] low);
    return 3'd7 - low;
  endfunction

  // 16-bit Galois LFSR step, taps 16,14,13,11.
  function automatic logic [15:0] lfsr_step(input logic [15:0] s);
    logic [15:0] n;
    n = {1'b0, s[15:1]};
    if (s[0]) n = n ^ 16'hB400;
    return n;
  endfunction

endpackage

// File: rtl/flux_cell_timer.sv
module flux_cell_timer #(
  parameter int ACC_W = 16,
  parameter int STEP  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic [ACC_W-1:0] bit_time_i,
  output logic             cell_done_o
);
  localparam int SW = ACC_W + 1;

  logic [ACC_W-1:0] acc_q;
  logic [SW-1:0]    sum;
  logic [SW-1:0]    period;

  function automatic logic [SW-1:0] add_step(input logic [ACC_W-1:0] a);
    return {1'b0, a} + SW'(STEP);
  endfunction

  function automatic logic [ACC_W-1:0] carry_rem(input logic [SW-1:0] s,
                                                  input logic [SW-1:0] p);
    logic [SW-1:0] r;
    r = s - p;
    return r[ACC_W-1:0];
  endfunction

  assign sum         = add_step(acc_q);
  assign period      = {1'b0, bit_time_i};
  assign cell_done_o = tick_i && (sum >= period);

  always_ff @(posedge clk) begin
    if (!rst_n)           acc_q <= '0;
    else if (cell_done_o) acc_q <= carry_rem(sum, period);
    else if (tick_i)      acc_q <= sum[ACC_W-1:0];
  end

  // R3
  rem_small_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_done_o && bit_time_i >= ACC_W'(STEP) && acc_q < bit_time_i)
      |=> (acc_q < ACC_W'(STEP)));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(acc_q));

endmodule

// File: rtl/flux_pos_counter.sv
module flux_pos_counter #(
  parameter int POS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_i,
  input  logic [POS_W-1:0] bit_count_i,
  output logic [POS_W-1:0] pos_o
);
  logic [POS_W-1:0] pos_q;

  function automatic logic [POS_W-1:0] next_pos(input logic [POS_W-1:0] p,
                                                 input logic [POS_W-1:0] c);
    logic [POS_W:0] inc;
    inc = {1'b0, p} + (POS_W+1)'(1);
    return (inc >= {1'b0, c}) ? '0 : inc[POS_W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)     pos_q <= '0;
    else if (adv_i) pos_q <= next_pos(pos_q, bit_count_i);
  end

  assign pos_o = pos_q;

  // R8
  wrap_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && bit_count_i != '0) |=> (pos_q < $past(bit_count_i)));

  // R9
  pos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_i |=> $stable(pos_q));

endmodule

// File: rtl/flux_head_shift.sv
module flux_head_shift #(
  parameter int HIST_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv_i,
  input  logic flux_bit_i,
  input  logic noise_bit_i,
  output logic head_zero_o,
  output logic pulse_o
);
  logic [HIST_W-1:0] head_q;
  logic [HIST_W-1:0] head_d;
  logic              pick;
  logic              pulse_q;

  assign head_d      = {head_q[HIST_W-2:0], flux_bit_i};
  assign head_zero_o = (head_d == '0);
  assign pick        = head_zero_o ? noise_bit_i : head_d[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q  <= '0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= adv_i ? pick : 1'b0;
      if (adv_i) head_q <= head_d;
    end
  end

  assign pulse_o = pulse_q;

  // R7
  quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_i |=> !pulse_o);

  // R6
  noise_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && head_zero_o) |=> (pulse_o == $past(noise_bit_i)));

  // R9
  head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_i |=> $stable(head_q));

endmodule

// File: rtl/flux_pulse_gen.sv
module flux_pulse_gen
  import flux_pkg::*;
#(
  parameter int         ACC_W      = 16,
  parameter int         POS_W      = 16,
  parameter int         STEP       = 4,
  parameter noise_src_e NOISE_KIND = NOISE_PORT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic [ACC_W-1:0] bit_time_i,
  input  logic [POS_W-1:0] bit_count_i,
  input  logic [7:0]       trk_byte_i,
  input  logic [7:0]       noise_byte_i,
  output logic             rd_pulse_o,
  output logic [POS_W-4:0] byte_addr_o,
  output logic [2:0]       bit_idx_o
);
  logic             cell_done;
  logic [POS_W-1:0] pos;
  logic             flux_bit;
  logic             noise_bit;
  logic             head_zero;

  flux_cell_timer #(.ACC_W(ACC_W), .STEP(STEP)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
    .bit_time_i(bit_time_i), .cell_done_o(cell_done));

  flux_pos_counter #(.POS_W(POS_W)) u_pos (
    .clk(clk), .rst_n(rst_n), .adv_i(cell_done),
    .bit_count_i(bit_count_i), .pos_o(pos));

  assign byte_addr_o = pos[POS_W-1:3];
  assign bit_idx_o   = msb_first_idx(pos[2:0]);
  assign flux_bit    = pick_bit(trk_byte_i, bit_idx_o);

  generate
    if (NOISE_KIND == NOISE_LFSR) begin : g_lfsr
      logic [15:0] lfsr_q;
      always_ff @(posedge clk) begin
        if (!rst_n)         lfsr_q <= 16'hACE1;
        else if (cell_done) lfsr_q <= lfsr_step(lfsr_q);
      end
      assign noise_bit = lfsr_q[0];
    end else begin : g_port
      assign noise_bit = pick_bit(noise_byte_i, bit_idx_o);
    end
  endgenerate

  flux_head_shift #(.HIST_W(4)) u_head (
    .clk(clk), .rst_n(rst_n), .adv_i(cell_done),
    .flux_bit_i(flux_bit), .noise_bit_i(noise_bit),
    .head_zero_o(head_zero), .pulse_o(rd_pulse_o));

  // R7
  pulse_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pulse_o |-> $past(tick_i));

  // R2
  done_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cell_done |-> tick_i);

endmodule

// File: tb/test_flux_pulse_gen.sv
module test_flux_pulse_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [15:0] bt = 16'd16;
  logic [15:0] cnt = 16'd256;
  logic [7:0]  trk_byte, noise_byte;
  logic        rd_pulse;
  logic [12:0] byte_addr;
  logic [2:0]  bit_idx;

  logic [7:0] trk_mem   [32];
  logic [7:0] noise_mem [32];

  int checks = 0;
  int errors = 0;
  bit started = 0;

  // reference model state
  int m_acc = 0, m_pos = 0, m_hist = 0, m_pulse = 0;

  always #4 clk = ~clk;

  assign trk_byte   = trk_mem[byte_addr[4:0]];
  assign noise_byte = noise_mem[byte_addr[4:0]];

  flux_pulse_gen i_flux_pulse_gen (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .bit_time_i(bt),
    .bit_count_i(cnt), .trk_byte_i(trk_byte), .noise_byte_i(noise_byte),
    .rd_pulse_o(rd_pulse), .byte_addr_o(byte_addr), .bit_idx_o(bit_idx));

  always @(posedge clk) begin
    int fb, bi, by;
    started = 1;
    if (!rst_n) begin
      m_acc = 0; m_pos = 0; m_hist = 0; m_pulse = 0;
    end else if (tick) begin
      m_acc = m_acc + 4;
      if (m_acc >= int'(bt)) begin
        by = (m_pos / 8) % 32;
        bi = 7 - (m_pos % 8);
        fb = (trk_mem[by] >> bi) & 1;
        m_hist = ((m_hist << 1) | fb) & 15;
        if (m_hist == 0) m_pulse = (noise_mem[by] >> bi) & 1;
        else             m_pulse = (m_hist >> 1) & 1;
        m_acc = m_acc - int'(bt);
        m_pos = (m_pos + 1 >= int'(cnt)) ? 0 : m_pos + 1;
      end else m_pulse = 0;
    end else m_pulse = 0;
  end

  always @(negedge clk) begin
    if (started) begin
      checks++;
      if (int'(rd_pulse) != m_pulse) begin
        errors++;
        $display("FAIL R5 R6 R7 rd_pulse: actual %0d expected %0d at %0t", rd_pulse, m_pulse, $time);
      end
      checks++;
      if (int'(byte_addr) != m_pos / 8) begin
        errors++;
        $display("FAIL R2 R3 R8 R9 byte_addr: actual %0d expected %0d at %0t", byte_addr, m_pos / 8, $time);
      end
      checks++;
      if (int'(bit_idx) != 7 - (m_pos % 8)) begin
        errors++;
        $display("FAIL R4 bit_idx: actual %0d expected %0d at %0t", bit_idx, 7 - (m_pos % 8), $time);
      end
    end
  end

  task automatic check_reset_state();
    checks++;
    if (rd_pulse !== 1'b0 || byte_addr !== 13'd0 || bit_idx !== 3'd7) begin
      errors++;
      $display("FAIL R1 reset state: actual pulse=%0b addr=%0d idx=%0d expected 0 0 7",
               rd_pulse, byte_addr, bit_idx);
    end
  endtask

  // mode 0: every cycle, 1: random, 2: every third cycle
  task automatic run(input int n, input int mode);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      case (mode)
        0: tick = 1'b1;
        1: tick = 1'($urandom % 2);
        default: tick = (c % 3 == 0);
      endcase
    end
    @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) begin
      trk_mem[i]   = 8'((i * 37 + 5) ^ 8'h5C);
      noise_mem[i] = 8'hFF;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: idle after reset
    check_reset_state();
    @(negedge clk);
    check_reset_state();

    // R2 R4 R5: steady ticks, period 16
    bt = 16'd16; cnt = 16'd256;
    run(2000, 0);

    // R3: period 14 carries remainder, random ticks (R7, R9)
    bt = 16'd14;
    run(2000, 1);

    // R6: zero region with mixed noise
    for (int i = 8; i < 24; i++) begin
      trk_mem[i]   = 8'h00;
      noise_mem[i] = 8'((i * 29) ^ 8'h96);
    end
    bt = 16'd8;
    run(3000, 0);

    // R8: wrap mid-byte, one cell per tick
    bt = 16'd4; cnt = 16'd13;
    run(600, 0);

    // R9: sparse ticks, odd period
    bt = 16'd18; cnt = 16'd100;
    run(1500, 2);

    // R1: reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check_reset_state();
    rst_n = 1'b1;
    bt = 16'd10; cnt = 16'd77;
    run(1500, 1);

    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule